// File: doc/BRIEF.md
# Audio Coprocessor Interval Timer Unit

This block provides three up-counting interval timers for a sound coprocessor, together with the shared control register that gates them. A free-running prescaler divides the base clock into a fast tick and a slow tick. The slow tick is eight times slower than the fast tick. Timer 2 advances on the fast tick. Timers 0 and 1 advance on the slow tick.

Each timer has an internal 8-bit divider, which counts ticks up to the timer's 8-bit target. When the divider reaches the target, it restarts and the timer's 4-bit output counter steps by one. Software reaches the block through a byte-wide register bus with a write strobe, a read strobe and a 3-bit address. Reading an output counter returns its value and also clears it. Bit 7 of the control register drives the boot ROM overlay enable.

There are two resets. A hard reset loads the power-on values. A soft reset clears the output counters to zero and leaves the prescaler running.

Top module: `tmr_unit`

## Requirements
- R1: The prescaler raises the fast tick once every FAST_DIV base clocks. It raises the slow tick on every eighth fast tick. Neither tick is ever high on two consecutive cycles.
- R2: Timer 2 advances only on fast ticks. Timers 0 and 1 advance only on slow ticks.
- R3: An enabled timer's divider counts ticks. On the tick that brings the divider to the target value, the divider restarts at 0 and the output counter increments. A target of 0 gives a period of 256 ticks.
- R4: The output counter is 4 bits wide and wraps from 15 to 0.
- R5: Control bit i (i = 0, 1, 2) enables timer i. A write that turns the bit from 0 to 1 clears that timer's divider and output counter. While the bit is 0, the timer holds its state.
- R6: The output `rom_enable` equals control bit 7.
- R7: The address map is: 0 = test, 1 = control, 2/3/4 = target of timer 0/1/2, 5/6/7 = output counter of timer 0/1/2. A read of addresses 0 to 4 returns 0. Read data appears on `bus_rdata` after the clock edge that samples `bus_rd`, and is held until the next read.
- R8: A read of address 5+i returns the output counter of timer i in bits 3:0, with zeros above, and clears that counter. If the counter would increment on the same edge, it becomes 1.
- R9: Hard reset sets control to 0xB0, so `rom_enable` = 1 and all timers are disabled. It sets every output counter to 0xF, every target and divider to 0, the prescaler to 0 and `bus_rdata` to 0.
- R10: Soft reset sets control to 0xB0 and clears every output counter and divider. It does not touch the prescaler or the targets. During soft reset, bus accesses are ignored.
- R11: Writing a target does not clear the prescaler or any divider. The new target is compared from the next tick onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous hard reset, active high |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rom_enable | output | 1 | Boot ROM overlay enable (control bit 7) |

## Verification
A control write takes effect at the clock edge that samples it, so `rom_enable` is compared a quarter period after that edge. Read data comes from a single register. It is compared a quarter period after the edge that sampled `bus_rd`, against the value the reference held just before that edge. Counter increments pass through no extra pipeline stage: the bench reference advances its prescaler, dividers and counters once per edge from the same inputs, so counts are due on exactly the edge where the tick and the divider match coincide. Same-edge collisions of read-clear, enable and tick therefore resolve the same way in the reference as the requirements state.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int NUM_TMR    = 3;
    localparam int DATA_W     = 8;
    localparam int CNT_W      = 4;
    localparam int ADDR_W     = 3;
    localparam int SLOW_SHIFT = 3;
    localparam int FAST_IDX   = 2;
    localparam int ROM_BIT    = 7;

    typedef enum logic [ADDR_W-1:0] {
        A_TEST = 3'd0,
        A_CTRL = 3'd1,
        A_TGT0 = 3'd2,
        A_TGT1 = 3'd3,
        A_TGT2 = 3'd4,
        A_OUT0 = 3'd5,
        A_OUT1 = 3'd6,
        A_OUT2 = 3'd7
    } reg_addr_e;

    localparam logic [DATA_W-1:0] CTRL_HARD = 8'hB0;
    localparam logic [CNT_W-1:0]  CNT_HARD  = 4'hF;
    localparam logic [CNT_W-1:0]  CNT_SOFT  = 4'h0;

    typedef struct packed {
        logic fast;
        logic slow;
    } tick_t;

    typedef struct packed {
        logic [NUM_TMR-1:0] en;
        logic               rom;
    } ctrl_t;

    function automatic logic [ADDR_W-1:0] tgt_addr(input int idx);
        return ADDR_W'(int'(A_TGT0) + idx);
    endfunction

    function automatic logic [ADDR_W-1:0] out_addr(input int idx);
        return ADDR_W'(int'(A_OUT0) + idx);
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int FAST_DIV = 4
) (
    input  logic  clk,
    input  logic  rst,
    output tick_t tick
);
    localparam int PRE_W = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;
    localparam int SUB_W = SLOW_SHIFT;

    logic [PRE_W-1:0] pre_q;
    logic [SUB_W-1:0] sub_q;
    logic             fast_hit;

    assign fast_hit  = (pre_q == PRE_W'(FAST_DIV - 1));
    assign tick.fast = fast_hit;
    assign tick.slow = fast_hit && (sub_q == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            sub_q <= '0;
        end else begin
            pre_q <= fast_hit ? '0 : pre_q + 1'b1;
            if (fast_hit) sub_q <= sub_q + 1'b1;
        end
    end

    generate
        if (FAST_DIV > 1) begin : g_fast_chk
            a_r1_fast_isolated: assert property (@(posedge clk) disable iff (rst)
                tick.fast |=> !tick.fast);
        end
    endgenerate

    a_r1_slow_isolated: assert property (@(posedge clk) disable iff (rst)
        tick.slow |=> !tick.slow);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              tick,
    input  logic              en_q,
    input  logic              en_rise,
    input  logic              tgt_we,
    input  logic [DATA_W-1:0] tgt_wdata,
    input  logic              rd_clr,
    output logic [CNT_W-1:0]  cnt
);
    logic [DATA_W-1:0] tgt_q;
    logic [DATA_W-1:0] div_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] div_n;
    logic              step;
    logic              hit;
    logic              inc;
    logic [CNT_W-1:0]  cnt_base;

    // 8-bit wrap makes a target of 0 match after 256 ticks
    assign step     = en_q && tick;
    assign div_n    = div_q + 1'b1;
    assign hit      = (div_n == tgt_q);
    assign inc      = step && hit;
    assign cnt_base = rd_clr ? '0 : cnt_q;
    assign cnt      = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q <= '0;
            div_q <= '0;
            cnt_q <= CNT_HARD;
        end else if (soft_rst) begin
            div_q <= '0;
            cnt_q <= CNT_SOFT;
        end else begin
            if (tgt_we) tgt_q <= tgt_wdata;
            if (en_rise) begin
                div_q <= '0;
                cnt_q <= '0;
            end else begin
                if (step) div_q <= hit ? '0 : div_n;
                cnt_q <= cnt_base + CNT_W'(inc);
            end
        end
    end

    a_r5_frozen: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (!en_q && !en_rise && !rd_clr) |=> ($stable(cnt_q) && $stable(div_q)));

    a_r5_start_clear: assert property (@(posedge clk) disable iff (rst || soft_rst)
        en_rise |=> (cnt_q == '0 && div_q == '0));

    a_r4_wrap: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (cnt_q == '1 && inc && !rd_clr && !en_rise) |=> (cnt_q == '0));

    a_r8_read_clear: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (rd_clr && !inc && !en_rise) |=> (cnt_q == '0));

    a_r11_tgt_keeps_div: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (tgt_we && !step && !en_rise) |=> $stable(div_q));

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int FAST_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rom_enable
);
    tick_t               tick;
    ctrl_t               ctrl_q;
    logic [NUM_TMR-1:0]  en_rise;
    logic [NUM_TMR-1:0]  tgt_we;
    logic [NUM_TMR-1:0]  rd_clr;
    logic [CNT_W-1:0]    cnt [NUM_TMR];
    logic                ctrl_we;
    logic [DATA_W-1:0]   rd_next;

    assign ctrl_we    = bus_wr && !soft_rst && (bus_addr == A_CTRL);
    assign rom_enable = ctrl_q.rom;

    tmr_prescale #(.FAST_DIV(FAST_DIV)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    generate
        for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
            logic ch_tick;
            if (i == FAST_IDX) begin : g_fast
                assign ch_tick = tick.fast;
            end else begin : g_slow
                assign ch_tick = tick.slow;
            end

            assign en_rise[i] = ctrl_we && bus_wdata[i] && !ctrl_q.en[i];
            assign tgt_we[i]  = bus_wr && !soft_rst && (bus_addr == tgt_addr(i));
            assign rd_clr[i]  = bus_rd && !soft_rst && (bus_addr == out_addr(i));

            tmr_channel u_ch (
                .clk       (clk),
                .rst       (rst),
                .soft_rst  (soft_rst),
                .tick      (ch_tick),
                .en_q      (ctrl_q.en[i]),
                .en_rise   (en_rise[i]),
                .tgt_we    (tgt_we[i]),
                .tgt_wdata (bus_wdata),
                .rd_clr    (rd_clr[i]),
                .cnt       (cnt[i])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            ctrl_q.en  <= CTRL_HARD[NUM_TMR-1:0];
            ctrl_q.rom <= CTRL_HARD[ROM_BIT];
        end else if (ctrl_we) begin
            ctrl_q.en  <= bus_wdata[NUM_TMR-1:0];
            ctrl_q.rom <= bus_wdata[ROM_BIT];
        end
    end

    always_comb begin
        rd_next = '0;
        case (reg_addr_e'(bus_addr))
            A_OUT0:  rd_next = {{(DATA_W-CNT_W){1'b0}}, cnt[0]};
            A_OUT1:  rd_next = {{(DATA_W-CNT_W){1'b0}}, cnt[1]};
            A_OUT2:  rd_next = {{(DATA_W-CNT_W){1'b0}}, cnt[2]};
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd && !soft_rst) begin
            bus_rdata <= rd_next;
        end
    end

    a_r7_zero_read: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !soft_rst && bus_addr <= A_TGT2) |=> (bus_rdata == '0));

    a_r6_rom_follows_write: assert property (@(posedge clk) disable iff (rst || soft_rst)
        ctrl_we |=> (rom_enable == $past(bus_wdata[ROM_BIT])));

    a_r10_soft_ctrl: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (rom_enable && ctrl_q.en == '0));

    a_r7_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd || soft_rst) |=> $stable(bus_rdata));

endmodule

// File: tb/tmr_unit_tb.sv
module tmr_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int FD         = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       soft_rst = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rom_enable;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    // reference state
    int         m_pre, m_sub;
    logic [7:0] m_ctrl;
    logic [7:0] m_tgt [3];
    logic [7:0] m_div [3];
    logic [3:0] m_cnt [3];
    logic [7:0] m_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_unit #(.FAST_DIV(FD)) dut_i (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rom_enable(rom_enable)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string read_tag(input logic [2:0] a);
        return (a >= 3'd5) ? "R8" : "R7";
    endfunction

    task automatic model_hard();
        m_pre = 0; m_sub = 0; m_ctrl = 8'h80; m_rd = 8'h00;
        for (int i = 0; i < 3; i++) begin
            m_tgt[i] = 8'h00; m_div[i] = 8'h00; m_cnt[i] = 4'hF;
        end
    endtask

    task automatic hard_reset();
        rst = 1'b1; bus_wr = 0; bus_rd = 0; soft_rst = 0;
        @(posedge clk); @(posedge clk);
        #(CLK_PERIOD/4);
        rst = 1'b0;
        model_hard();
        check(rom_enable == 1'b1, "R9 rom_enable after hard reset", rom_enable, 1);
        check(bus_rdata == 8'h00, "R9 rdata after hard reset", bus_rdata, 0);
    endtask

    // one cycle: drive, clock, advance reference, check
    task automatic cyc(input logic wr, input logic rd, input logic [2:0] a,
                       input logic [7:0] d, input logic sr, input string tag);
        bit fast, slow, tk, en, rise, rc, inc;
        logic [7:0] nd;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; soft_rst = sr;
        @(posedge clk);
        fast = (m_pre == FD-1);
        slow = fast && (m_sub == 7);
        if (sr) begin
            m_ctrl = 8'h80;
            for (int i = 0; i < 3; i++) begin m_div[i] = 0; m_cnt[i] = 0; end
        end else begin
            if (rd) m_rd = (a >= 3'd5) ? {4'h0, m_cnt[a-3'd5]} : 8'h00;
            for (int i = 0; i < 3; i++) begin
                tk   = (i == 2) ? fast : slow;
                en   = m_ctrl[i];
                rise = wr && (a == 3'd1) && d[i] && !en;
                rc   = rd && (a == 3'(5 + i));
                if (rise) begin
                    m_div[i] = 0; m_cnt[i] = 0;
                end else begin
                    inc = 0;
                    if (en && tk) begin
                        nd = m_div[i] + 8'd1;
                        if (nd == m_tgt[i]) begin m_div[i] = 0; inc = 1; end
                        else m_div[i] = nd;
                    end
                    m_cnt[i] = (rc ? 4'h0 : m_cnt[i]) + 4'(inc);
                end
                if (wr && a == 3'(2 + i)) m_tgt[i] = d;
            end
            if (wr && a == 3'd1) m_ctrl = d & 8'h87;
        end
        if (fast) m_sub = (m_sub + 1) % 8;
        m_pre = (m_pre + 1) % FD;
        #(CLK_PERIOD/4);
        if (rd && !sr)
            check(bus_rdata == m_rd, (tag != "") ? tag : read_tag(a), bus_rdata, m_rd);
        check(rom_enable == m_ctrl[7], "R6 rom_enable", rom_enable, m_ctrl[7]);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, "");
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        cyc(1, 0, a, d, 0, "");
    endtask

    task automatic rd_reg(input logic [2:0] a, input string tag);
        cyc(0, 1, a, 0, 0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        hard_reset();

        // R9: power-on counters read 0xF, control/test/targets read 0
        rd_reg(3'd5, "R9 counter0 power-on");
        rd_reg(3'd6, "R9 counter1 power-on");
        rd_reg(3'd7, "R9 counter2 power-on");
        rd_reg(3'd5, "R8 counter0 cleared by read");
        rd_reg(3'd0, "R7 test reads zero");
        rd_reg(3'd1, "R7 control reads zero");

        // R1/R2: timer 2 with target 1 steps on each fast tick
        wr_reg(3'd4, 8'd1);
        wr_reg(3'd2, 8'd1);
        wr_reg(3'd1, 8'h84);
        idle(FD * 3);
        rd_reg(3'd7, "R1 fast tick rate on timer2");
        rd_reg(3'd5, "R2 timer0 idle while timer2 runs");
        // R4: wrap past 15
        idle(FD * 18);
        rd_reg(3'd7, "R4 counter wraps");
        // R3: target 3, then target 0 = 256
        wr_reg(3'd4, 8'd3);
        idle(FD * 10);
        rd_reg(3'd7, "R3 period of three ticks");
        wr_reg(3'd4, 8'd0);
        idle(FD * 256 * 2 + 20);
        rd_reg(3'd7, "R3 zero target means 256");
        rd_reg(3'd2, "R7 target reads zero");
        // R6: rom bit off
        wr_reg(3'd1, 8'h04);
        // R2: timers 0/1 on slow tick
        wr_reg(3'd2, 8'd2);
        wr_reg(3'd3, 8'd1);
        wr_reg(3'd1, 8'h07);
        idle(FD * 8 * 5);
        rd_reg(3'd5, "R2 timer0 slow tick");
        rd_reg(3'd6, "R2 timer1 slow tick");
        // R5: freeze, then restart clears
        wr_reg(3'd1, 8'h03);
        idle(3);
        rd_reg(3'd7, "R8 read before freeze");
        idle(FD * 300);
        rd_reg(3'd7, "R5 frozen timer holds");
        wr_reg(3'd1, 8'h07);
        rd_reg(3'd7, "R5 restart clears counter");
        // R11: target change mid-count keeps divider
        wr_reg(3'd4, 8'd5);
        idle(FD * 2);
        wr_reg(3'd4, 8'd7);
        idle(FD * 20);
        rd_reg(3'd7, "R11 target write keeps divider");
        // R10: soft reset
        idle(FD * 9);
        cyc(1, 1, 3'd1, 8'h00, 1, "");
        rd_reg(3'd5, "R10 soft reset counter0");
        rd_reg(3'd7, "R10 soft reset counter2");
        check(rom_enable == 1'b1, "R10 rom_enable after soft reset", rom_enable, 1);

        // constrained random phase
        for (int k = 0; k < 20000; k++) begin
            int r;
            logic [2:0] a;
            logic [7:0] d;
            r = int'($urandom % 100);
            a = 3'($urandom % 8);
            d = 8'($urandom);
            if (r < 3)       wr_reg(3'd1, d);
            else if (r < 6)  wr_reg(3'(2 + $urandom % 3), 8'($urandom % 6));
            else if (r < 14) rd_reg(a, "");
            else if (r < 15) cyc(0, 0, 0, 0, 1, "R10 random soft reset");
            else if (r < 16) cyc(1, 1, a, d, 0, "");
            else             idle(1);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

endmodule